// File: doc/BRIEF.md
# Framed Byte-Stream Register Access Controller

This block is a slave that sits on a pair of 8-bit byte streams. Each stream has a valid/ready handshake and first/last frame markers. A request frame opens with a header byte. The low nibble of the header is the command and the high nibble is a register address. The controller reads or writes one of eight 8-bit registers held inside the block. It then sends a response frame on the output stream.

The response always repeats the request header as its first beat. A read inserts the register value as a middle beat. The frame closes with a footer byte that carries an error flag, which is set when the address does not name an existing register. A write whose data byte lacks the last marker is dropped without a response. Between accepted response beats the output valid goes low for one cycle.

Top module: `regacc_frame_ctrl`

## Requirements
- R1: After reset (rst_ni low, asynchronous), out_valid_o and in_ready_o are 0, and a read of any register returns 0.
- R2: A header byte carries the command in bits [3:0] (0 = read, 1 = write) and the address in bits [7:4]. A read request is one byte with both in_first_i and in_last_i set. The first response beat equals the request header, with out_first_o=1 and out_last_o=0.
- R3: A write request is a header with in_first_i set and in_last_i clear, followed by a data byte with in_last_i set. This stores the data byte in the addressed register. The response is header then footer, and for a valid address the footer value is 0.
- R4: A read response is header, then data, then footer. The data beat has both markers clear and holds the addressed register's value. For a valid address the footer value is 0.
- R5: Addresses 8 to 15 are invalid. For these the footer value is 1, the read data beat is 0, and a write leaves every register unchanged.
- R6: A write data byte accepted without in_last_i is discarded. No register changes and no response frame is produced.
- R7: After every accepted response beat, out_valid_o is 0 for exactly one cycle. It then rises again if the frame has another beat. After the footer it stays 0.
- R8: While out_valid_o=1 and out_ready_i=0, out_data_o, out_valid_o, out_first_o and out_last_o hold steady. out_first_o and out_last_o are never 1 together.
- R9: in_ready_o is 1 only while waiting for a header (and only for a byte with in_first_i set) or while waiting for write data. Bytes without in_first_i are not taken while a header is awaited. in_ready_o is 0 throughout a response.
- R10: The stored header does not change once the header has been taken. The error flag is 0 during request phases. No register is written while a read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_data_i | input | 8 | Request byte |
| in_valid_i | input | 1 | Request byte valid |
| in_first_i | input | 1 | Request byte opens a frame |
| in_last_i | input | 1 | Request byte closes a frame |
| in_ready_o | output | 1 | Request byte accepted this cycle when valid |
| out_data_o | output | 8 | Response byte |
| out_valid_o | output | 1 | Response byte valid |
| out_first_o | output | 1 | Response header beat |
| out_last_o | output | 1 | Response footer beat |
| out_ready_i | input | 1 | Downstream takes the response byte |

## Verification
The assertions assume that the upstream source follows the handshake. A presented request byte is never withdrawn or altered before it is taken. Every frame uses the read or write command, with the marker combination that matches it. The stimulus drives each byte at a falling edge and holds it until a rising edge sees in_ready_o high. It uses only well-formed read and write frames, plus the discard case, which is itself a legal write header followed by a data byte without the last marker. A byte lacking the first marker is only offered while a header is awaited, and it is withdrawn before a real header is sent.

// File: rtl/regacc_pkg.sv
package regacc_pkg;
  localparam int CMD_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_GET_HDR = 3'd1,
    ST_GET_DAT = 3'd2,
    ST_SET_DAT = 3'd3,
    ST_SND_HDR = 3'd4,
    ST_SND_DAT = 3'd5,
    ST_SND_FTR = 3'd6
  } state_e;

  localparam logic [CMD_W-1:0] CMD_RD = 4'd0;
  localparam logic [CMD_W-1:0] CMD_WR = 4'd1;
endpackage

// File: rtl/regacc_regfile.sv
module regacc_regfile #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 4,
  parameter int NUM_REGS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              addr_ok_o
);
  localparam logic [ADDR_W:0] NUM_L = (ADDR_W+1)'(NUM_REGS);

  logic [DATA_W-1:0] regs_q [NUM_REGS];

  assign addr_ok_o = {1'b0, addr_i} < NUM_L;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs_q[g] <= '0;
      else if (wr_en_i && addr_i == ADDR_W'(g))
        regs_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr_i == ADDR_W'(i)) rd_data_o = regs_q[i];
  end
endmodule

// File: rtl/regacc_ctrl.sv
module regacc_ctrl
  import regacc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_valid_i,
  input  logic              in_first_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  input  logic              out_valid_i,
  input  logic              out_ready_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              addr_ok_i,
  output logic              wr_en_o,
  output state_e            state_o,
  output logic [DATA_W-1:0] hdr_o,
  output logic [DATA_W-1:0] dat_o,
  output logic              err_o,
  output logic              gap_o
);
  state_e            state_q, state_d;
  logic [DATA_W-1:0] hdr_q, hdr_d, dat_q, dat_d;
  logic              err_q, err_d, gap_q, gap_d;
  logic              in_acc, out_acc;
  logic [CMD_W-1:0]  in_cmd, hdr_cmd;

  assign in_cmd  = in_data_i[CMD_W-1:0];
  assign hdr_cmd = hdr_q[CMD_W-1:0];

  always_comb begin
    unique case (state_q)
      ST_GET_HDR: in_ready_o = in_first_i;
      ST_SET_DAT: in_ready_o = 1'b1;
      default:    in_ready_o = 1'b0;
    endcase
  end

  assign in_acc  = in_valid_i && in_ready_o;
  assign out_acc = out_valid_i && out_ready_i;
  assign wr_en_o = (state_q == ST_SET_DAT) && in_acc && in_last_i && addr_ok_i;

  always_comb begin
    state_d = state_q;
    hdr_d   = hdr_q;
    dat_d   = dat_q;
    err_d   = err_q;
    gap_d   = out_acc;
    unique case (state_q)
      ST_IDLE: state_d = ST_GET_HDR;
      ST_GET_HDR: if (in_acc) begin
        hdr_d = in_data_i;
        if (in_cmd == CMD_RD && in_last_i)       state_d = ST_GET_DAT;
        else if (in_cmd == CMD_WR && !in_last_i) state_d = ST_SET_DAT;
        else                                     state_d = ST_IDLE;
      end
      ST_GET_DAT: begin
        dat_d   = addr_ok_i ? rd_data_i : '0;
        err_d   = !addr_ok_i;
        state_d = ST_SND_HDR;
      end
      ST_SET_DAT: if (in_acc) begin
        if (in_last_i) begin
          err_d   = !addr_ok_i;
          state_d = ST_SND_HDR;
        end else begin
          state_d = ST_IDLE;  // unterminated write: drop frame
        end
      end
      ST_SND_HDR: if (out_acc) state_d = (hdr_cmd == CMD_RD) ? ST_SND_DAT : ST_SND_FTR;
      ST_SND_DAT: if (out_acc) state_d = ST_SND_FTR;
      ST_SND_FTR: if (out_acc) begin
        err_d   = 1'b0;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hdr_q   <= '0;
      dat_q   <= '0;
      err_q   <= 1'b0;
      gap_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      hdr_q   <= hdr_d;
      dat_q   <= dat_d;
      err_q   <= err_d;
      gap_q   <= gap_d;
    end
  end

  assign state_o = state_q;
  assign hdr_o   = hdr_q;
  assign dat_o   = dat_q;
  assign err_o   = err_q;
  assign gap_o   = gap_q;
endmodule

// File: rtl/regacc_tx.sv
module regacc_tx
  import regacc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  state_e            state_i,
  input  logic              gap_i,
  input  logic [DATA_W-1:0] hdr_i,
  input  logic [DATA_W-1:0] dat_i,
  input  logic              err_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_valid_o,
  output logic              out_first_o,
  output logic              out_last_o
);
  logic send_st;

  assign send_st     = state_i inside {ST_SND_HDR, ST_SND_DAT, ST_SND_FTR};
  assign out_valid_o = send_st && !gap_i;
  assign out_first_o = out_valid_o && (state_i == ST_SND_HDR);
  assign out_last_o  = out_valid_o && (state_i == ST_SND_FTR);

  always_comb begin
    unique case (state_i)
      ST_SND_HDR: out_data_o = hdr_i;
      ST_SND_DAT: out_data_o = dat_i;
      ST_SND_FTR: out_data_o = {{(DATA_W-1){1'b0}}, err_i};
      default:    out_data_o = '0;
    endcase
  end
endmodule

// File: rtl/regacc_frame_ctrl.sv
module regacc_frame_ctrl
  import regacc_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_valid_i,
  input  logic              in_first_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_valid_o,
  output logic              out_first_o,
  output logic              out_last_o,
  input  logic              out_ready_i
);
  localparam int ADDR_W = DATA_W - CMD_W;

  state_e            state_w;
  logic [DATA_W-1:0] hdr_w, dat_w, rd_data_w;
  logic              err_w, gap_w, wr_en_w, addr_ok_w;

  regacc_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_data_i  (in_data_i),
    .in_valid_i (in_valid_i),
    .in_first_i (in_first_i),
    .in_last_i  (in_last_i),
    .in_ready_o (in_ready_o),
    .out_valid_i(out_valid_o),
    .out_ready_i(out_ready_i),
    .rd_data_i  (rd_data_w),
    .addr_ok_i  (addr_ok_w),
    .wr_en_o    (wr_en_w),
    .state_o    (state_w),
    .hdr_o      (hdr_w),
    .dat_o      (dat_w),
    .err_o      (err_w),
    .gap_o      (gap_w)
  );

  regacc_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_w),
    .addr_i   (hdr_w[DATA_W-1:CMD_W]),
    .wr_data_i(in_data_i),
    .rd_data_o(rd_data_w),
    .addr_ok_o(addr_ok_w)
  );

  regacc_tx #(.DATA_W(DATA_W)) u_tx (
    .state_i    (state_w),
    .gap_i      (gap_w),
    .hdr_i      (hdr_w),
    .dat_i      (dat_w),
    .err_i      (err_w),
    .out_data_o (out_data_o),
    .out_valid_o(out_valid_o),
    .out_first_o(out_first_o),
    .out_last_o (out_last_o)
  );
endmodule

// File: rtl/regacc_frame_ctrl_chk.sv
module regacc_frame_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_first_i,
  input logic              in_ready_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_valid_o,
  input logic              out_first_o,
  input logic              out_last_o,
  input logic              out_ready_i,
  input logic [2:0]        state_i,
  input logic [DATA_W-1:0] hdr_i,
  input logic              err_i,
  input logic              wr_en_i
);
  assert_state_legal_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i <= 3'd6);

  assert_idle_to_hdr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == 3'd0 |=> state_i == 3'd1);

  assert_hold_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> $stable(out_data_o) && out_valid_o);

  assert_hold_marks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> $stable(out_first_o) && $stable(out_last_o));

  assert_marks_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({out_first_o, out_last_o}));

  assert_marks_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_first_o || out_last_o) |-> out_valid_o);

  assert_gap_after_beat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i |=> !out_valid_o);

  assert_hdr_echo_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_first_o |-> out_data_o == hdr_i);

  assert_ready_states_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> (state_i == 3'd3) || (state_i == 3'd1 && in_first_i));

  assert_hdr_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i > 3'd1 |=> $stable(hdr_i));

  assert_err_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i inside {3'd1, 3'd2, 3'd3} |-> !err_i);

  assert_no_wr_on_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != 3'd3) |-> !wr_en_i);

  assert_in_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && state_i == 3'd0 |-> !in_ready_o);
endmodule

bind regacc_frame_ctrl regacc_frame_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_first_i (in_first_i),
  .in_ready_o (in_ready_o),
  .out_data_o (out_data_o),
  .out_valid_o(out_valid_o),
  .out_first_o(out_first_o),
  .out_last_o (out_last_o),
  .out_ready_i(out_ready_i),
  .state_i    (state_w),
  .hdr_i      (hdr_w),
  .err_i      (err_w),
  .wr_en_i    (wr_en_w)
);

// File: tb/sim_regacc_frame_ctrl.sv
`timescale 1ns/1ps
module sim_regacc_frame_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] in_data_i = '0;
  logic       in_valid_i = 1'b0, in_first_i = 1'b0, in_last_i = 1'b0;
  logic       in_ready_o;
  logic [7:0] out_data_o;
  logic       out_valid_o, out_first_o, out_last_o;
  logic       out_ready_i = 1'b0;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_reg [8];

  always #10 clk_i = ~clk_i;

  regacc_frame_ctrl u0 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .in_data_i(in_data_i), .in_valid_i(in_valid_i), .in_first_i(in_first_i),
    .in_last_i(in_last_i), .in_ready_o(in_ready_o),
    .out_data_o(out_data_o), .out_valid_o(out_valid_o), .out_first_o(out_first_o),
    .out_last_o(out_last_o), .out_ready_i(out_ready_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input bit f, input bit l);
    int g = 0;
    @(negedge clk_i);
    in_data_i = b; in_first_i = f; in_last_i = l; in_valid_i = 1'b1;
    #1;
    while (!in_ready_o && g < 50) begin
      @(negedge clk_i); #1; g++;
    end
    chk(in_ready_o, "R9 request byte accepted", int'(in_ready_o), 1);
    @(posedge clk_i);
    @(negedge clk_i);
    in_valid_i = 1'b0; in_first_i = 1'b0; in_last_i = 1'b0;
  endtask

  // take one response beat after 'delay' stalled cycles
  task automatic recv(output logic [7:0] d, output logic f, output logic l,
                      input int delay, input bit more);
    int g = 0;
    logic [7:0] d0;
    logic f0, l0;
    while (!out_valid_o && g < 50) begin
      @(negedge clk_i); g++;
    end
    chk(out_valid_o, "R7 beat presented", int'(out_valid_o), 1);
    d0 = out_data_o; f0 = out_first_o; l0 = out_last_o;
    for (int i = 0; i < delay; i++) begin
      @(negedge clk_i);
      chk(out_valid_o && out_data_o == d0 && out_first_o == f0 && out_last_o == l0,
          "R8 hold under stall", int'(out_data_o), int'(d0));
      chk(!in_ready_o, "R9 no intake during response", int'(in_ready_o), 0);
    end
    chk(!(out_first_o && out_last_o), "R8 markers exclusive", int'({out_first_o, out_last_o}), 0);
    d = out_data_o; f = out_first_o; l = out_last_o;
    out_ready_i = 1'b1;
    @(negedge clk_i);
    out_ready_i = 1'b0;
    chk(!out_valid_o, "R7 valid low after beat", int'(out_valid_o), 0);
    @(negedge clk_i);
    chk(out_valid_o == more, "R7 single bubble", int'(out_valid_o), int'(more));
  endtask

  task automatic do_read(input logic [3:0] a, input int delay);
    logic [7:0] d; logic f, l;
    bit ok = (a < 4'd8);
    send({a, 4'h0}, 1'b1, 1'b1);
    recv(d, f, l, delay, 1'b1);
    chk(d == {a, 4'h0} && f && !l, "R2 header echo", int'(d), int'({a, 4'h0}));
    recv(d, f, l, delay, 1'b1);
    if (ok) chk(d == exp_reg[a[2:0]] && !f && !l, "R4 read data", int'(d), int'(exp_reg[a[2:0]]));
    else    chk(d == 8'h00 && !f && !l, "R5 invalid read data zero", int'(d), 0);
    recv(d, f, l, delay, 1'b0);
    chk(l && !f, "R4 footer marker", int'(l), 1);
    if (ok) chk(d == 8'h00, "R4 footer ok", int'(d), 0);
    else    chk(d == 8'h01, "R5 footer error", int'(d), 1);
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] v, input int delay);
    logic [7:0] d; logic f, l;
    bit ok = (a < 4'd8);
    send({a, 4'h1}, 1'b1, 1'b0);
    send(v, 1'b0, 1'b1);
    if (ok) exp_reg[a[2:0]] = v;
    recv(d, f, l, delay, 1'b1);
    chk(d == {a, 4'h1} && f && !l, "R3 write header echo", int'(d), int'({a, 4'h1}));
    recv(d, f, l, delay, 1'b0);
    chk(l && !f, "R3 footer follows header", int'(l), 1);
    if (ok) chk(d == 8'h00, "R3 footer ok", int'(d), 0);
    else    chk(d == 8'h01, "R5 write footer error", int'(d), 1);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) exp_reg[i] = 8'h00;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(!out_valid_o && !in_ready_o, "R1 outputs idle in reset",
        int'({out_valid_o, in_ready_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!out_valid_o, "R1 no response after reset", int'(out_valid_o), 0);
    do_read(4'd0, 0);
    do_read(4'd7, 0);
  endtask

  task automatic t_discard;
    send({4'd2, 4'h1}, 1'b1, 1'b0);
    send(8'hEE, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk(!out_valid_o, "R6 no response for dropped write", int'(out_valid_o), 0);
    end
    do_read(4'd2, 0);
  endtask

  task automatic t_no_start;
    @(negedge clk_i);
    in_data_i = 8'h01; in_valid_i = 1'b1; in_first_i = 1'b0; in_last_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      #1;
      chk(!in_ready_o, "R9 byte without first not taken", int'(in_ready_o), 0);
      @(negedge clk_i);
    end
    in_valid_i = 1'b0; in_last_i = 1'b0;
    do_read(4'd0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    do_write(4'd3, 8'hA5, 0);
    do_read(4'd3, 0);
    do_write(4'd0, 8'h5A, 2);
    do_write(4'd7, 8'hFF, 1);
    do_read(4'd0, 3);
    do_read(4'd7, 1);
    do_write(4'd2, 8'h3C, 0);
    t_discard();
    do_read(4'd9, 0);
    do_write(4'd15, 8'h77, 2);
    do_read(4'd7, 0);
    do_read(4'd3, 0);
    t_no_start();
    do_read(4'd8, 2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule